// File: doc/BRIEF.md
# Multi-Output Video Timing Generator

This block generates the raster timing for a display pipeline. A pixel counter runs across each line and a line counter runs down each field. The two counters advance only on cycles where the pixel-clock enable is high, and fields alternate between top and bottom. From this one raster the block drives four sync output pairs, each placed independently, so every downstream interface can receive syncs shifted to match its own pipeline delay. It also drives an active-video window signal and two field-start interrupts.

Software configures the block through a word-addressed write port and reads it back through a combinational read port. It sets the line length, the field length in half-lines, the window corners for each field, and five words per sync output. It then writes the restart command. The field-start events set sticky status bits. A mask with separate set and clear aliases selects which status bits raise the interrupt line.

Top module: `vtg_multi_sync`

## Requirements
- R1: After reset, every hsync, vsync, active and irq output is 0, the status and mask registers read 0, and the raster starts in the top field at line 1, pixel 0.
- R2: The pixel count runs 0 to LINE_LEN-1. At the line end (pixel+1 >= LINE_LEN) it returns to 0 and the line count steps. The line count runs from 1 to HALF_LINES/2 (integer division) and then returns to 1, toggling the field between top and bottom. The counters move only on cycles with pix_ce high.
- R3: Each output's hsync word packs start in bits [15:0] and stop in bits [31:16]. Hsync is high while the pixel is in [start, stop). The range wraps past the line end when stop < start, and hsync stays low when start equals stop.
- R4: Each output has a vsync line word (rise line [15:0], fall line [31:16]) and an offset word (rise pixel [15:0], fall pixel [31:16]). Vsync is high from the rise position (inclusive) to the fall position (exclusive), ordered by line and then by pixel. It wraps across the field end and stays low when the two positions are equal. The top field uses the top-field words and the bottom field uses the bottom-field words.
- R5: Active is high when line and pixel both lie inside the inclusive rectangle set by the current field's start and stop window words, each packed as line [31:16] and pixel [15:0].
- R6: The hsync, vsync and active outputs are registered and reflect the counter position held before the clock edge that updates them.
- R7: Writing a value with bit 0 set to the restart address puts the raster at the top field, line 1, pixel 0 at that edge. The restart takes priority over advancing. A write to that address with bit 0 clear has no effect.
- R8: Status bit 1 (top) or bit 0 (bottom) is set on a cycle with pix_ce high while the raster sits at line 1, pixel 0 of that field. Writing 1s to the status-clear address clears those bits, and a set in the same cycle wins.
- R9: Writing 1s to the mask-set address sets mask bits, and writing 1s to the mask-clear address clears them. irq is the OR of (status AND mask).
- R10: Word address map: 0 line length, 1 half-lines per field, 2 restart, 3 status (read), 4 status clear, 5 mask (read), 6 mask set, 7 mask clear, 8/9 top window start/stop, 10/11 bottom window start/stop, 32+8*n+k for output n with k = 0 hsync, 1 top vsync line, 2 bottom vsync line, 3 top vsync offset, 4 bottom vsync offset. Addresses 0, 1, 3 and 5 read back, with their values in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel-clock enable; counters advance when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| hsync | output | 4 | Horizontal sync, one bit per output |
| vsync | output | 4 | Vertical sync, one bit per output |
| active | output | 1 | Active-video window |
| irq | output | 1 | Masked field-start interrupt |

## Verification
A wrong pixel or line count moves every sync edge and every window edge at once. Within one line, hsync and active then fall off the expected pattern on all four outputs. A wrong field flag swaps the top and bottom vsync and window geometry, and the bench gives the two fields different values, so the error shows in the first field after the toggle. A lost or misplaced field event shows on irq, and on the status read, one cycle after the first pixel of the field.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int DW = 32;
  localparam int HW = 16;

  localparam int A_LINELEN  = 0;
  localparam int A_HALFLN   = 1;
  localparam int A_RESTART  = 2;
  localparam int A_STS      = 3;
  localparam int A_STS_CLR  = 4;
  localparam int A_MASK     = 5;
  localparam int A_MSK_SET  = 6;
  localparam int A_MSK_CLR  = 7;
  localparam int A_WIN_BASE = 8;
  localparam int A_OUT_BASE = 32;
  localparam int A_OUT_STEP = 8;

  typedef struct packed {
    logic [DW-1:0] hs;
    logic [DW-1:0] vl_top;
    logic [DW-1:0] vl_bot;
    logic [DW-1:0] vo_top;
    logic [DW-1:0] vo_bot;
  } sync_cfg_t;

  // half-open span [a,b) on a circular axis; empty when a == b
  function automatic logic span_hit(input logic [DW-1:0] p, a, b);
    if (a <= b) return (p >= a) && (p < b);
    return (p >= a) || (p < b);
  endfunction

  // inclusive rectangle, corners packed as {line, pixel}
  function automatic logic box_hit(input logic [HW-1:0] ln, px,
                                   input logic [DW-1:0] st, sp);
    return (ln >= st[DW-1:HW]) && (ln <= sp[DW-1:HW]) &&
           (px >= st[HW-1:0]) && (px <= sp[HW-1:0]);
  endfunction
endpackage

// File: rtl/vtg_raster.sv
module vtg_raster
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          restart,
  input  logic [HW-1:0] line_len,
  input  logic [HW-1:0] half_lines,
  output logic [HW-1:0] pix,
  output logic [HW-1:0] line,
  output logic          is_bot,
  output logic          evt_top,
  output logic          evt_bot
);
  logic          at_start;
  logic          line_end;
  logic          field_end;
  logic [HW:0]   n_lines;

  assign n_lines   = {2'b00, half_lines[HW-1:1]};
  assign at_start  = (line == HW'(1)) && (pix == '0);
  assign line_end  = ({1'b0, pix} + 1'b1) >= {1'b0, line_len};
  assign field_end = {1'b0, line} >= n_lines;
  assign evt_top   = ce && at_start && !is_bot;
  assign evt_bot   = ce && at_start && is_bot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix    <= '0;
      line   <= HW'(1);
      is_bot <= 1'b0;
    end else if (restart) begin
      pix    <= '0;
      line   <= HW'(1);
      is_bot <= 1'b0;
    end else if (ce) begin
      if (line_end) begin
        pix <= '0;
        if (field_end) begin
          line   <= HW'(1);
          is_bot <= !is_bot;
        end else begin
          line <= line + 1'b1;
        end
      end else begin
        pix <= pix + 1'b1;
      end
    end
  end

  // R2
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !restart) |=> ($stable(pix) && $stable(line) && $stable(is_bot)));
  // R2
  field_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(is_bot) |-> (line == HW'(1) && pix == '0));
  // R2
  line_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line != '0);
endmodule

// File: rtl/vtg_sync_out.sv
module vtg_sync_out
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] pix,
  input  logic [HW-1:0] line,
  input  logic          is_bot,
  input  sync_cfg_t     cfg,
  output logic          hs_o,
  output logic          vs_o
);
  logic [DW-1:0] vl, vo, pos, rise_key, fall_key;
  logic          hs_d, vs_d;

  assign vl       = is_bot ? cfg.vl_bot : cfg.vl_top;
  assign vo       = is_bot ? cfg.vo_bot : cfg.vo_top;
  assign pos      = {line, pix};
  assign rise_key = {vl[HW-1:0], vo[HW-1:0]};
  assign fall_key = {vl[DW-1:HW], vo[DW-1:HW]};
  assign hs_d     = span_hit({{HW{1'b0}}, pix}, {{HW{1'b0}}, cfg.hs[HW-1:0]},
                             {{HW{1'b0}}, cfg.hs[DW-1:HW]});
  assign vs_d     = span_hit(pos, rise_key, fall_key);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_o <= 1'b0;
      vs_o <= 1'b0;
    end else begin
      hs_o <= hs_d;
      vs_o <= vs_d;
    end
  end

  // R3
  hs_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.hs[HW-1:0] == cfg.hs[DW-1:HW]) |=> !hs_o);
  // R4
  vs_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_key == fall_key) |=> !vs_o);
endmodule

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int AW    = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic [AW-1:0]              rd_addr,
  output logic [DW-1:0]              rd_data,
  input  logic                       evt_top,
  input  logic                       evt_bot,
  output logic [HW-1:0]              line_len,
  output logic [HW-1:0]              half_lines,
  output logic                       restart,
  output logic [3:0][DW-1:0]         win,
  output sync_cfg_t [N_OUT-1:0]      cfg,
  output logic                       irq
);
  logic [1:0] sts, mask, sts_clr;
  int         wa;

  assign wa      = int'(wr_addr);
  assign restart = wr_en && (wa == A_RESTART) && wr_data[0];
  assign sts_clr = (wr_en && wa == A_STS_CLR) ? wr_data[1:0] : 2'b00;
  assign irq     = |(sts & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_len   <= '0;
      half_lines <= '0;
      win        <= '0;
      cfg        <= '0;
      sts        <= '0;
      mask       <= '0;
    end else begin
      if (wr_en) begin
        case (wa)
          A_LINELEN: line_len   <= wr_data[HW-1:0];
          A_HALFLN:  half_lines <= wr_data[HW-1:0];
          A_MSK_SET: mask       <= mask | wr_data[1:0];
          A_MSK_CLR: mask       <= mask & ~wr_data[1:0];
          default: ;
        endcase
        for (int w = 0; w < 4; w++)
          if (wa == A_WIN_BASE + w) win[w] <= wr_data;
        for (int i = 0; i < N_OUT; i++) begin
          if (wa == A_OUT_BASE + i*A_OUT_STEP + 0) cfg[i].hs     <= wr_data;
          if (wa == A_OUT_BASE + i*A_OUT_STEP + 1) cfg[i].vl_top <= wr_data;
          if (wa == A_OUT_BASE + i*A_OUT_STEP + 2) cfg[i].vl_bot <= wr_data;
          if (wa == A_OUT_BASE + i*A_OUT_STEP + 3) cfg[i].vo_top <= wr_data;
          if (wa == A_OUT_BASE + i*A_OUT_STEP + 4) cfg[i].vo_bot <= wr_data;
        end
      end
      sts <= (sts & ~sts_clr) | {evt_top, evt_bot};
    end
  end

  always_comb begin
    case (int'(rd_addr))
      A_LINELEN: rd_data = {{(DW-HW){1'b0}}, line_len};
      A_HALFLN:  rd_data = {{(DW-HW){1'b0}}, half_lines};
      A_STS:     rd_data = {{(DW-2){1'b0}}, sts};
      A_MASK:    rd_data = {{(DW-2){1'b0}}, mask};
      default:   rd_data = '0;
    endcase
  end

  // R8
  sts_top_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_top |=> sts[1]);
  // R8
  sts_bot_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wa == A_STS_CLR && wr_data[0] && !evt_bot) |=> !sts[0]);
  // R9
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wa == A_MSK_SET) |=> ((mask & $past(wr_data[1:0])) == $past(wr_data[1:0])));
endmodule

// File: rtl/vtg_multi_sync.sv
module vtg_multi_sync
  import vtg_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_ce,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [N_OUT-1:0] hsync,
  output logic [N_OUT-1:0] vsync,
  output logic             active,
  output logic             irq
);
  localparam int ADDR_SPAN = A_OUT_BASE + N_OUT * A_OUT_STEP;

  logic [HW-1:0]         line_len, half_lines, pix, line;
  logic                  is_bot, evt_top, evt_bot, restart, act_d;
  logic [3:0][DW-1:0]    win;
  sync_cfg_t [N_OUT-1:0] cfg;

  initial if (ADDR_SPAN > (1 << AW)) $error("address space too small for N_OUT");

  vtg_regs #(.N_OUT(N_OUT), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_top(evt_top), .evt_bot(evt_bot),
    .line_len(line_len), .half_lines(half_lines), .restart(restart),
    .win(win), .cfg(cfg), .irq(irq)
  );

  vtg_raster u_raster (
    .clk(clk), .rst_n(rst_n), .ce(pix_ce), .restart(restart),
    .line_len(line_len), .half_lines(half_lines), .pix(pix), .line(line),
    .is_bot(is_bot), .evt_top(evt_top), .evt_bot(evt_bot)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    vtg_sync_out u_out (
      .clk(clk), .rst_n(rst_n), .pix(pix), .line(line), .is_bot(is_bot),
      .cfg(cfg[g]), .hs_o(hsync[g]), .vs_o(vsync[g])
    );
  end

  assign act_d = is_bot ? box_hit(line, pix, win[2], win[3])
                        : box_hit(line, pix, win[0], win[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else        active <= act_d;
  end

  // R7
  restart_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pix == '0 && line == HW'(1) && !is_bot));
endmodule

// File: tb/tb_vtg_multi_sync.sv
module tb_vtg_multi_sync;
  localparam int N = 4;

  logic        clk = 0, rst_n = 0, pix_ce = 0, wr_en = 0;
  logic [5:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [N-1:0] hsync, vsync;
  logic        active, irq;

  int checks = 0, errors = 0;

  int m_pix, m_line, m_bot, m_len, m_half;
  int m_hs[N], m_vlt[N], m_vlb[N], m_vot[N], m_vob[N];
  int m_win[4];
  int m_sts, m_mask;

  always #2 clk = ~clk;

  vtg_multi_sync dut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .hsync(hsync),
    .vsync(vsync), .active(active), .irq(irq)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (pix=%0d line=%0d bot=%0d)",
               what, act, exp, m_pix, m_line, m_bot);
    end
  endtask

  // span is the complement of [b,a) when it wraps
  function automatic bit e_span(int p, int a, int b);
    if (a == b) return 0;
    if (a < b) return (p >= a) && (p < b);
    return !((p >= b) && (p < a));
  endfunction

  function automatic bit e_box(int ln, int px, int st, int sp);
    return ln >= (st >>> 16) && ln <= (sp >>> 16) &&
           px >= (st & 16'hFFFF) && px <= (sp & 16'hFFFF);
  endfunction

  function automatic int lo(int w); return w & 16'hFFFF; endfunction
  function automatic int hi(int w); return (w >>> 16) & 16'hFFFF; endfunction

  task automatic cyc(input bit ce, input bit we, input int addr, input logic [31:0] d);
    int key, vl, vo, ev_t, ev_b, clr;
    pix_ce = ce; wr_en = we; wr_addr = 6'(addr); wr_data = d;
    @(posedge clk); #1;
    // R6: outputs follow the position held before this edge
    key = m_line * 65536 + m_pix;
    for (int i = 0; i < N; i++) begin
      vl = m_bot ? m_vlb[i] : m_vlt[i];
      vo = m_bot ? m_vob[i] : m_vot[i];
      chk(hsync[i] == e_span(m_pix, lo(m_hs[i]), hi(m_hs[i])), "R3,R6 hsync",
          int'(hsync[i]), int'(e_span(m_pix, lo(m_hs[i]), hi(m_hs[i]))));
      chk(vsync[i] == e_span(key, lo(vl)*65536 + lo(vo), hi(vl)*65536 + hi(vo)),
          "R4,R6 vsync", int'(vsync[i]),
          int'(e_span(key, lo(vl)*65536 + lo(vo), hi(vl)*65536 + hi(vo))));
    end
    // R5 and R2 (window placement depends on counters)
    chk(active == (m_bot ? e_box(m_line, m_pix, m_win[2], m_win[3])
                         : e_box(m_line, m_pix, m_win[0], m_win[1])),
        "R5,R2 active", int'(active), -1);
    // model update, R8 events from the pre-edge position
    ev_t = (ce && m_line == 1 && m_pix == 0 && !m_bot);
    ev_b = (ce && m_line == 1 && m_pix == 0 && m_bot);
    clr  = (we && addr == 4) ? int'(d[1:0]) : 0;
    if (we && addr == 2 && d[0]) begin // R7
      m_pix = 0; m_line = 1; m_bot = 0;
    end else if (ce) begin
      if (m_pix + 1 >= m_len) begin
        m_pix = 0;
        if (m_line >= m_half / 2) begin m_line = 1; m_bot = !m_bot; end
        else m_line++;
      end else m_pix++;
    end
    m_sts = (m_sts & ~clr) | (ev_t << 1) | ev_b;
    if (we) begin
      case (addr)
        0: m_len = lo(d);
        1: m_half = lo(d);
        6: m_mask = m_mask | int'(d[1:0]);
        7: m_mask = m_mask & ~int'(d[1:0]);
        8, 9, 10, 11: m_win[addr-8] = d;
        default: ;
      endcase
      for (int i = 0; i < N; i++) begin
        if (addr == 32 + 8*i + 0) m_hs[i]  = d;
        if (addr == 32 + 8*i + 1) m_vlt[i] = d;
        if (addr == 32 + 8*i + 2) m_vlb[i] = d;
        if (addr == 32 + 8*i + 3) m_vot[i] = d;
        if (addr == 32 + 8*i + 4) m_vob[i] = d;
      end
    end
    // R9
    chk(irq == ((m_sts & m_mask) != 0), "R9 irq", int'(irq), int'((m_sts & m_mask) != 0));
  endtask

  task automatic rd_chk(input int addr, input int exp, input string what);
    rd_addr = 6'(addr); #1;
    chk(int'(rd_data) == exp, what, int'(rd_data), exp);
  endtask

  task automatic wr(input int addr, input int d);
    cyc($urandom % 2, 1, addr, 32'(d));
  endtask

  task automatic run(input int n, input int ce_pct, input bit irq_ops);
    for (int c = 0; c < n; c++) begin
      if (irq_ops && ($urandom % 40) == 0) cyc($urandom % 100 < ce_pct, 1, 4, 32'($urandom % 4));
      else if (irq_ops && ($urandom % 60) == 0) cyc(1, 1, 6 + $urandom % 2, 32'($urandom % 4));
      else cyc($urandom % 100 < ce_pct, 0, 0, 0);
      if ((c % 97) == 0) rd_chk(3, m_sts, "R8 status read");
    end
  endtask

  task automatic program_random();
    int len, nl;
    len = 6 + $urandom % 11;
    nl  = 3 + $urandom % 4;
    wr(0, len);
    wr(1, 2 * nl);
    for (int i = 0; i < N; i++) begin
      wr(32 + 8*i + 0, (($urandom % len) << 16) | ($urandom % len));
      wr(32 + 8*i + 1, ((1 + $urandom % nl) << 16) | (1 + $urandom % nl));
      wr(32 + 8*i + 2, ((1 + $urandom % nl) << 16) | (1 + $urandom % nl));
      wr(32 + 8*i + 3, (($urandom % len) << 16) | ($urandom % len));
      wr(32 + 8*i + 4, (($urandom % len) << 16) | ($urandom % len));
    end
    for (int w = 0; w < 4; w++)
      wr(8 + w, (((w % 2) ? nl - $urandom % 2 : 1 + $urandom % 2) << 16) |
                ((w % 2) ? len - 1 - $urandom % 3 : $urandom % 3));
    rd_chk(0, len, "R10 line length readback");
    rd_chk(1, 2 * nl, "R10 half-line readback");
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240506));
    m_pix = 0; m_line = 1; m_bot = 0; m_len = 0; m_half = 0; m_sts = 0; m_mask = 0;
    for (int i = 0; i < N; i++) begin m_hs[i]=0; m_vlt[i]=0; m_vlb[i]=0; m_vot[i]=0; m_vob[i]=0; end
    for (int w = 0; w < 4; w++) m_win[w] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk(hsync == 0 && vsync == 0, "R1 syncs after reset", int'({hsync, vsync}), 0);
    chk(active == 0 && irq == 0, "R1 active/irq after reset", int'({active, irq}), 0);
    rd_chk(3, 0, "R1 status after reset");
    rd_chk(5, 0, "R1 mask after reset");
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);

    // directed: wrap hsync, null hsync, wrapping vsync, differing fields
    cyc(0, 1, 0, 10);
    cyc(0, 1, 1, 8);                           // 4 lines per field
    cyc(0, 1, 32 + 0, (2 << 16) | 7);          // R3 wraps: stop < start
    cyc(0, 1, 40 + 0, (5 << 16) | 5);          // R3 start == stop
    cyc(0, 1, 48 + 0, (6 << 16) | 0);
    cyc(0, 1, 56 + 0, (9 << 16) | 3);
    cyc(0, 1, 32 + 1, (1 << 16) | 4);          // R4 top rise line 4, fall line 1 (wraps)
    cyc(0, 1, 32 + 3, (2 << 16) | 8);
    cyc(0, 1, 32 + 2, (3 << 16) | 2);          // R4 bottom differs
    cyc(0, 1, 32 + 4, (0 << 16) | 5);
    cyc(0, 1, 40 + 1, (2 << 16) | 2);          // R4 equal positions: never
    cyc(0, 1, 40 + 3, (4 << 16) | 4);
    cyc(0, 1, 8, (2 << 16) | 1);  cyc(0, 1, 9, (3 << 16) | 8);   // R5 top window
    cyc(0, 1, 10, (1 << 16) | 0); cyc(0, 1, 11, (4 << 16) | 9);  // R5 bottom window
    cyc(0, 1, 6, 3);                            // R9 mask set both
    rd_chk(5, 3, "R9 mask after set");
    cyc(0, 1, 2, 1);                            // R7 restart
    run(20, 0, 0);                              // R2 ce low: nothing moves
    run(200, 100, 0);
    rd_chk(3, m_sts, "R8 both field events seen");
    cyc(1, 1, 2, 0);                            // R7 bit0 clear: no effect
    run(7, 100, 0);
    cyc(1, 1, 2, 1);                            // R7 restart mid-line
    cyc(1, 1, 4, 3);                            // R8 set at field start beats clear
    rd_chk(3, m_sts, "R8 set wins over clear");
    cyc(1, 1, 7, 1);                            // R9 mask clear bottom
    rd_chk(5, 2, "R9 mask after clear");
    run(150, 75, 1);

    for (int k = 0; k < 6; k++) begin
      program_random();
      cyc(1, 1, 2, 1);
      run(600, 70 + 10 * (k % 3), 1);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule